// File: doc/BRIEF.md
# Watchdog Timer with Byte-Split Self-Test

This block supervises software by counting ticks of a selected reference clock and demanding a reset when the count reaches a programmable 16-bit limit, unless a refresh pulse restarts the count first. With the warning interrupt enabled, the first timeout raises an interrupt and restarts the count. The reset then follows one full timeout period later if no refresh arrives. The block keeps a fallback path for the case where the bus clock dies while the interrupt is still being serviced. That path works whenever the counter runs from a clock other than the bus clock.

Separate run enables decide whether counting continues in debug, wait and stop states. Debug and stop counting also require a reference clock other than the bus clock. For fast power-up testing, the counter can be split into its two byte stages. The low stage can be checked on its own. The high stage can be checked while it is fed from bit 7 of the low stage, so the carry link between the stages is exercised. A test timeout sets a sticky pass flag and asserts reset.

The block is clocked by the system clock. The reference clock arrives as a one-cycle tick enable. The reset output stays asserted until the synchronous system reset clears the block.

Top module: `wdb_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `wd_irq`, `wd_reset` and `test_pass` are 0 and the counter is 0.
- R2: With `test_sel`=00 (full 16-bit mode) and `irq_enable`=0, `wd_reset` rises at the T-th counted tick, where T=`timeout_val` (nonzero), and not before.
- R3: With `irq_enable`=1 in full mode, the T-th counted tick sets `wd_irq` and leaves `wd_reset` low. `wd_reset` rises after T further counted ticks with no refresh.
- R4: A `refresh` pulse clears the counter and the pending interrupt. The next timeout then needs a full T counted ticks.
- R5: With `wd_enable`=0 no tick is counted. In wait state (`mode_wait`=1) ticks count only when `run_in_wait`=1.
- R6: In stop state (`mode_stop`=1) ticks count only when `run_in_stop`=1, `run_in_wait`=1 and `ref_is_bus`=0. `wd_irq` may assert in stop state.
- R7: In debug state (`mode_debug`=1, which takes precedence over wait and stop) ticks count only when `run_in_debug`=1 and `ref_is_bus`=0.
- R8: Once `wd_reset` is 1 it stays 1, whatever `refresh` or the ticks do, until `rst_n` goes low.
- R9: If `irq_enable`=1 and `ref_is_bus`=0, and `bus_clk_on` drops while the interrupt is pending, the next timeout asserts `wd_reset` even when the bus clock is still off.
- R10: If `ref_is_bus`=1 and `bus_clk_on`=0 when the second timeout occurs, the normal reset is blocked: `wd_reset` stays 0 and `wd_irq` stays 1.
- R11: With `test_sel`=01 only the low byte counts. A timeout occurs at the tick where it reaches `timeout_val[7:0]`.
- R12: With `test_sel`=10 the high byte advances on every toggle of low-byte bit 7, which happens every 128 ticks. A timeout occurs when the high byte reaches `timeout_val[15:8]`.
- R13: A test-mode timeout sets `test_pass` and asserts `wd_reset` at the same edge, even when `irq_enable`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| ref_tick | input | 1 | One-cycle tick of the selected reference clock |
| ref_is_bus | input | 1 | 1 when the reference clock is the bus clock |
| bus_clk_on | input | 1 | 1 while the bus clock is running |
| mode_debug | input | 1 | Core is halted for debug |
| mode_wait | input | 1 | Chip is in wait state |
| mode_stop | input | 1 | Chip is in stop state |
| wd_enable | input | 1 | Watchdog counting enable |
| run_in_debug | input | 1 | Keep counting in debug state |
| run_in_wait | input | 1 | Keep counting in wait state |
| run_in_stop | input | 1 | Keep counting in stop state |
| irq_enable | input | 1 | Warning interrupt before reset |
| test_sel | input | 2 | 00/11 full, 01 low-byte test, 10 high-byte test |
| timeout_val | input | 16 | Timeout limit |
| refresh | input | 1 | Refresh pulse, clears count and warning |
| wd_irq | output | 1 | Warning interrupt |
| wd_reset | output | 1 | Reset request, sticky |
| test_pass | output | 1 | Sticky byte-test pass flag |

## Verification
The assertions assume that `refresh` and `ref_tick` are single-cycle pulses. They also assume that `timeout_val` and `test_sel` are held steady while counting and that `timeout_val` is nonzero. The stop-state hold check assumes the debug indicator is low whenever it applies. The directed stimulus sets all configuration during reset or while the counter is gated. It only changes `bus_clk_on` and the mode flags between ticks, and it always programs a nonzero limit.

// File: rtl/wdb_pkg.sv
// Package: shared types of the byte-split watchdog.
// Assumes nothing; holds only type definitions.
package wdb_pkg;
    // Counter test selection as seen on the test_sel pins.
    typedef enum logic [1:0] {
        TM_FULL  = 2'b00,
        TM_LOW   = 2'b01,
        TM_HIGH  = 2'b10,
        TM_SPARE = 2'b11
    } test_mode_e;

    // Escalation state of the timeout handler.
    typedef enum logic [1:0] {
        ESC_IDLE   = 2'b00,
        ESC_WARN   = 2'b01,
        ESC_BACKUP = 2'b10,
        ESC_FIRED  = 2'b11
    } esc_state_e;
endpackage

// File: rtl/wdb_mode_gate.sv
// Module: decides whether a reference tick is counted.
// Assumes ref_tick is a one-cycle enable in the clk domain. Debug takes
// precedence over stop, and stop over wait. Purely combinational.
module wdb_mode_gate (
    input  logic ref_tick,
    input  logic ref_is_bus,
    input  logic mode_debug,
    input  logic mode_wait,
    input  logic mode_stop,
    input  logic wd_enable,
    input  logic run_in_debug,
    input  logic run_in_wait,
    input  logic run_in_stop,
    input  logic halted,
    output logic cnt_en
);
    logic mode_ok;

    // Pick the permission that applies to the current power/debug state.
    always_comb begin
        if (mode_debug)
            mode_ok = run_in_debug && !ref_is_bus;
        else if (mode_stop)
            mode_ok = run_in_stop && run_in_wait && !ref_is_bus;
        else if (mode_wait)
            mode_ok = run_in_wait;
        else
            mode_ok = 1'b1;
    end

    // Count only an enabled, permitted tick while no reset is pending.
    always_comb cnt_en = ref_tick && wd_enable && mode_ok && !halted;
endmodule

// File: rtl/wdb_split_counter.sv
// Module: the watchdog counter, built from two byte stages.
// Assumes WIDTH is even and the limit stays steady while counting.
// In full mode the stages form one WIDTH-bit counter. In low-byte test mode
// only the low stage counts. In high-byte test mode the high stage advances
// on each toggle of the low stage's top bit. A hit clears the count.
module wdb_split_counter
    import wdb_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             clear,
    input  test_mode_e       test_mode,
    input  logic [WIDTH-1:0] limit,
    output logic [WIDTH-1:0] count,
    output logic             full_hit,
    output logic             test_hit
);
    localparam int STAGE = WIDTH / 2;

    logic [STAGE-1:0] lo_q, hi_q, lo_nxt, hi_nxt;
    logic [STAGE-1:0] lo_inc, hi_step;
    logic [WIDTH-1:0] full_inc;
    logic             top_toggle;

    // Incremented values of each stage and of the joined counter.
    always_comb begin
        lo_inc     = lo_q + 1'b1;
        full_inc   = {hi_q, lo_q} + 1'b1;
        top_toggle = lo_inc[STAGE-1] != lo_q[STAGE-1];
        hi_step    = hi_q + STAGE'(top_toggle);
    end

    // Next-state and match logic for the selected counting variant.
    always_comb begin
        lo_nxt   = lo_q;
        hi_nxt   = hi_q;
        full_hit = 1'b0;
        test_hit = 1'b0;
        if (cnt_en) begin
            unique case (test_mode)
                TM_LOW: begin
                    test_hit = lo_inc == limit[STAGE-1:0];
                    lo_nxt   = test_hit ? '0 : lo_inc;
                end
                TM_HIGH: begin
                    test_hit = top_toggle && (hi_step == limit[WIDTH-1:STAGE]);
                    lo_nxt   = test_hit ? '0 : lo_inc;
                    hi_nxt   = test_hit ? '0 : hi_step;
                end
                default: begin
                    full_hit = full_inc == limit;
                    lo_nxt   = full_hit ? '0 : full_inc[STAGE-1:0];
                    hi_nxt   = full_hit ? '0 : full_inc[WIDTH-1:STAGE];
                end
            endcase
        end
    end

    // Stage registers; a refresh clear overrides counting.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_nxt;
            hi_q <= hi_nxt;
        end
    end

    assign count = {hi_q, lo_q};
endmodule

// File: rtl/wdb_escalate.sv
// Module: turns counter hits into the warning interrupt, the reset request
// and the test pass flag. Assumes the hits are one-cycle pulses. The reset
// request is sticky until rst_n. The fallback path arms only with the
// interrupt enabled and a reference clock other than the bus clock.
module wdb_escalate
    import wdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic full_hit,
    input  logic test_hit,
    input  logic refresh,
    input  logic irq_enable,
    input  logic ref_is_bus,
    input  logic bus_clk_on,
    output logic wd_irq,
    output logic wd_reset,
    output logic test_pass
);
    esc_state_e state_q;
    logic       backup_armed;

    // Fallback reset may only be relied on when the counter clock is independent.
    always_comb backup_armed = irq_enable && !ref_is_bus;

    // Escalation sequence: idle, warning, fallback pending, fired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ESC_IDLE;
            test_pass <= 1'b0;
        end else if (state_q != ESC_FIRED) begin
            if (test_hit) begin
                state_q   <= ESC_FIRED;
                test_pass <= 1'b1;
            end else if (refresh) begin
                state_q <= ESC_IDLE;
            end else begin
                unique case (state_q)
                    ESC_IDLE:
                        if (full_hit)
                            state_q <= irq_enable ? ESC_WARN : ESC_FIRED;
                    ESC_WARN:
                        if (full_hit) begin
                            if (bus_clk_on || backup_armed)
                                state_q <= ESC_FIRED;
                        end else if (!bus_clk_on && backup_armed) begin
                            state_q <= ESC_BACKUP;
                        end
                    ESC_BACKUP:
                        if (full_hit)
                            state_q <= ESC_FIRED;
                    default: state_q <= state_q;
                endcase
            end
        end
    end

    // Decode the outputs from the state.
    always_comb begin
        wd_irq   = (state_q == ESC_WARN) || (state_q == ESC_BACKUP);
        wd_reset = state_q == ESC_FIRED;
    end
endmodule

// File: rtl/wdb_top.sv
// Module: top of the byte-split watchdog. Joins the mode gate, the split
// counter and the escalation logic. Assumes all inputs are synchronous to clk
// and that the reference clock reaches it as a one-cycle tick.
module wdb_top
    import wdb_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             ref_is_bus,
    input  logic             bus_clk_on,
    input  logic             mode_debug,
    input  logic             mode_wait,
    input  logic             mode_stop,
    input  logic             wd_enable,
    input  logic             run_in_debug,
    input  logic             run_in_wait,
    input  logic             run_in_stop,
    input  logic             irq_enable,
    input  logic [1:0]       test_sel,
    input  logic [WIDTH-1:0] timeout_val,
    input  logic             refresh,
    output logic             wd_irq,
    output logic             wd_reset,
    output logic             test_pass
);
    logic             cnt_en;
    logic             full_hit;
    logic             test_hit;
    logic [WIDTH-1:0] count_q;
    test_mode_e       test_mode;

    // Map the raw selection pins onto the mode type.
    always_comb test_mode = test_mode_e'(test_sel);

    wdb_mode_gate gate_i (
        .ref_tick     (ref_tick),
        .ref_is_bus   (ref_is_bus),
        .mode_debug   (mode_debug),
        .mode_wait    (mode_wait),
        .mode_stop    (mode_stop),
        .wd_enable    (wd_enable),
        .run_in_debug (run_in_debug),
        .run_in_wait  (run_in_wait),
        .run_in_stop  (run_in_stop),
        .halted       (wd_reset),
        .cnt_en       (cnt_en)
    );

    wdb_split_counter #(.WIDTH(WIDTH)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .clear     (refresh),
        .test_mode (test_mode),
        .limit     (timeout_val),
        .count     (count_q),
        .full_hit  (full_hit),
        .test_hit  (test_hit)
    );

    wdb_escalate esc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .full_hit   (full_hit),
        .test_hit   (test_hit),
        .refresh    (refresh),
        .irq_enable (irq_enable),
        .ref_is_bus (ref_is_bus),
        .bus_clk_on (bus_clk_on),
        .wd_irq     (wd_irq),
        .wd_reset   (wd_reset),
        .test_pass  (test_pass)
    );
endmodule

// File: rtl/wdb_checker.sv
// Module: property checker for wdb_top, attached by bind.
// Assumes single-cycle refresh pulses and the debug flag low in stop checks.
module wdb_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             refresh,
    input logic             wd_enable,
    input logic             mode_debug,
    input logic             mode_stop,
    input logic             ref_is_bus,
    input logic             wd_irq,
    input logic             wd_reset,
    input logic             test_pass,
    input logic [WIDTH-1:0] count_q
);
    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset |=> wd_reset); // R8

    AST_WARN_BEFORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_irq) |-> !wd_reset); // R3

    AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh && !wd_reset) |=> (!wd_irq && count_q == '0)); // R4

    AST_DISABLED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_enable && !refresh) |=> $stable(count_q)); // R5

    AST_STOP_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stop && !mode_debug && ref_is_bus && !refresh) |=> $stable(count_q)); // R6

    AST_PASS_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n)
        test_pass |-> wd_reset); // R13
endmodule

bind wdb_top wdb_checker #(.WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .refresh    (refresh),
    .wd_enable  (wd_enable),
    .mode_debug (mode_debug),
    .mode_stop  (mode_stop),
    .ref_is_bus (ref_is_bus),
    .wd_irq     (wd_irq),
    .wd_reset   (wd_reset),
    .test_pass  (test_pass),
    .count_q    (count_q)
);

// File: tb/wdb_top_tb_top.sv
// Directed bench for wdb_top: one task per scenario, each checking itself.
module wdb_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_tick, ref_is_bus, bus_clk_on;
    logic        mode_debug, mode_wait, mode_stop;
    logic        wd_enable, run_in_debug, run_in_wait, run_in_stop, irq_enable;
    logic [1:0]  test_sel;
    logic [15:0] timeout_val;
    logic        refresh;
    logic        wd_irq, wd_reset, test_pass;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdb_top dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ref_is_bus(ref_is_bus),
        .bus_clk_on(bus_clk_on), .mode_debug(mode_debug), .mode_wait(mode_wait),
        .mode_stop(mode_stop), .wd_enable(wd_enable), .run_in_debug(run_in_debug),
        .run_in_wait(run_in_wait), .run_in_stop(run_in_stop), .irq_enable(irq_enable),
        .test_sel(test_sel), .timeout_val(timeout_val), .refresh(refresh),
        .wd_irq(wd_irq), .wd_reset(wd_reset), .test_pass(test_pass)
    );

    task automatic check(input string req, input string what,
                         input logic actual, input logic expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, actual, expected);
        end
    endtask

    // Reset with a given limit and defaults: enabled, run state, bus clock on.
    task automatic do_reset(input logic [15:0] limit);
        @(negedge clk);
        rst_n = 1'b0; ref_tick = 1'b0; ref_is_bus = 1'b0; bus_clk_on = 1'b1;
        mode_debug = 1'b0; mode_wait = 1'b0; mode_stop = 1'b0;
        wd_enable = 1'b1; run_in_debug = 1'b0; run_in_wait = 1'b0;
        run_in_stop = 1'b0; irq_enable = 1'b0; test_sel = 2'b00;
        timeout_val = limit; refresh = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ref_tick = 1'b1;
            @(negedge clk) ref_tick = 1'b0;
        end
    endtask

    task automatic pulse_refresh();
        @(negedge clk) refresh = 1'b1;
        @(negedge clk) refresh = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset(16'd10);
        check("R1", "irq after reset", wd_irq, 1'b0);
        check("R1", "reset after reset", wd_reset, 1'b0);
        check("R1", "pass after reset", test_pass, 1'b0);
        tick(9);  // a zero count needs all 10 ticks
        check("R1", "count starts at zero", wd_reset, 1'b0);
    endtask

    task automatic t_direct_reset();
        do_reset(16'd10);
        tick(9);
        check("R2", "no reset at T-1", wd_reset, 1'b0);
        tick(1);
        check("R2", "reset at T", wd_reset, 1'b1);
        check("R2", "no irq", wd_irq, 1'b0);
    endtask

    task automatic t_warn_then_reset();
        do_reset(16'd10);
        irq_enable = 1'b1;
        tick(10);
        check("R3", "irq at first timeout", wd_irq, 1'b1);
        check("R3", "no reset at first timeout", wd_reset, 1'b0);
        tick(9);
        check("R3", "no reset before second", wd_reset, 1'b0);
        tick(1);
        check("R3", "reset at second timeout", wd_reset, 1'b1);
    endtask

    task automatic t_refresh();
        do_reset(16'd10);
        irq_enable = 1'b1;
        tick(10);
        pulse_refresh();
        check("R4", "irq cleared by refresh", wd_irq, 1'b0);
        tick(9);
        check("R4", "count restarted", wd_irq, 1'b0);
        check("R4", "no reset", wd_reset, 1'b0);
        tick(1);
        check("R4", "irq after full period", wd_irq, 1'b1);
    endtask

    task automatic t_enable_wait();
        do_reset(16'd10);
        wd_enable = 1'b0;
        tick(15);
        check("R5", "disabled does not count", wd_reset, 1'b0);
        wd_enable = 1'b1;
        mode_wait = 1'b1;
        tick(15);
        check("R5", "wait without run enable held", wd_reset, 1'b0);
        run_in_wait = 1'b1;
        tick(9);
        check("R5", "wait count from zero", wd_reset, 1'b0);
        tick(1);
        check("R5", "wait with run enable fires", wd_reset, 1'b1);
    endtask

    task automatic t_stop();
        do_reset(16'd10);
        irq_enable = 1'b1;
        mode_stop = 1'b1; run_in_stop = 1'b1;
        tick(12);
        check("R6", "stop without wait enable held", wd_irq, 1'b0);
        run_in_wait = 1'b1; ref_is_bus = 1'b1;
        tick(12);
        check("R6", "stop on bus clock held", wd_irq, 1'b0);
        ref_is_bus = 1'b0;
        tick(10);
        check("R6", "irq asserts in stop", wd_irq, 1'b1);
    endtask

    task automatic t_debug();
        do_reset(16'd10);
        mode_debug = 1'b1; mode_wait = 1'b1; run_in_wait = 1'b1;
        tick(12);
        check("R7", "debug without run enable held", wd_reset, 1'b0);
        run_in_debug = 1'b1; ref_is_bus = 1'b1;
        tick(12);
        check("R7", "debug on bus clock held", wd_reset, 1'b0);
        ref_is_bus = 1'b0;
        tick(10);
        check("R7", "debug counts on other clock", wd_reset, 1'b1);
    endtask

    task automatic t_sticky();
        do_reset(16'd4);
        tick(4);
        pulse_refresh();
        tick(20);
        check("R8", "reset held after refresh and ticks", wd_reset, 1'b1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R8", "system reset clears reset", wd_reset, 1'b0);
    endtask

    task automatic t_backup();
        do_reset(16'd10);
        irq_enable = 1'b1;
        tick(10);
        bus_clk_on = 1'b0;
        tick(9);
        check("R9", "no reset before second timeout", wd_reset, 1'b0);
        tick(1);
        check("R9", "fallback reset with bus off", wd_reset, 1'b1);
    endtask

    task automatic t_blocked();
        do_reset(16'd10);
        irq_enable = 1'b1; ref_is_bus = 1'b1;
        tick(10);
        bus_clk_on = 1'b0;
        tick(10);
        check("R10", "normal reset blocked", wd_reset, 1'b0);
        check("R10", "irq still pending", wd_irq, 1'b1);
    endtask

    task automatic t_low_test();
        do_reset(16'h0305);
        test_sel = 2'b01;
        tick(4);
        check("R11", "low byte not yet", wd_reset, 1'b0);
        tick(1);
        check("R11", "low byte timeout", wd_reset, 1'b1);
        check("R11", "pass flag", test_pass, 1'b1);
    endtask

    task automatic t_high_test();
        do_reset(16'h0203);
        test_sel = 2'b10; irq_enable = 1'b1;
        tick(255);
        check("R12", "high byte not yet", wd_reset, 1'b0);
        check("R13", "no pass yet", test_pass, 1'b0);
        tick(1);
        check("R12", "high byte timeout at 256", wd_reset, 1'b1);
        check("R13", "pass set with irq enabled", test_pass, 1'b1);
        check("R13", "no warning in test", wd_irq, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_direct_reset();
        t_warn_then_reset();
        t_refresh();
        t_enable_wait();
        t_stop();
        t_debug();
        t_sticky();
        t_backup();
        t_blocked();
        t_low_test();
        t_high_test();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule